// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-visible register front end of an interrupt redirection controller that serves 24 input pins. Software reaches every internal register through two bus-visible locations. It first writes a register number into a selector at byte offset 0x00. It then reads or writes the chosen register through a data port at offset 0x10. The chosen register can be the controller identifier, a read-only version word, an arbitration word, or one 32-bit half of a 64-bit redirection entry. Each entry holds the vector, the delivery attributes, the trigger and mask controls, and the destination of one input pin.

The block stores the redirection table and the identifier. A separate interrupt engine reads any entry through a combinational lookup port. The engine sets or clears an entry's remote-IRR flag through a side port. It also supplies a per-pin pending vector. Whenever software rewrites an entry whose pin is pending, the block sends the engine a one-cycle service request naming that pin. The engine then re-evaluates delivery for that pin.

Top module: `irq_redir_regs`

## Requirements
- R1: A bus write at offset 0x00 stores all 32 data bits in the selector. A read there returns the selector. Read data appears on `busRdata` in the cycle after the read request, and `busRdata` is 0 in every cycle that does not follow a read request.
- R2: Reads at any offset other than 0x00 and 0x10 return 0. Writes there change no state.
- R3: With selector 0, the data port holds a 4-bit identifier in bits 27:24. A write stores data bits 27:24, and a read returns the identifier there with all other bits 0.
- R4: With selector 1, a read returns 0x00170011: the highest entry number (23) in bits 23:16 and the version code 0x11 in bits 7:0. Writes are ignored.
- R5: With selector 2, a read returns the identifier in bits 27:24. Writes are ignored.
- R6: A selector of 0x10 or above addresses entry (selector − 0x10) >> 1. Selector bit 0 set picks entry bits 63:32, and clear picks bits 31:0. Entry fields are: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote IRR [14], trigger mode [15], mask [16], and destination [63:56].
- R7: A write to the lower half replaces entry bits 31:0 and forces remote IRR (bit 14) to 0. A write to the upper half replaces bits 63:32 and leaves the lower half unchanged.
- R8: A selector that names entry 24 or higher, or a value from 3 to 0x0F, reads as 0 and discards writes.
- R9: After reset, every entry equals 0x0000_0000_0001_0000 (only the mask bit 16 set), the identifier is 0, and the selector is 0.
- R10: An accepted entry write whose pin bit in `pendingBits` is 1 in the write cycle raises `svcReq` for exactly the following cycle, with `svcPin` set to the entry number. Any other cycle has `svcReq` at 0.
- R11: A side-port request writes `remoteSetVal` into remote IRR of entry `remoteSetIdx`, visible from the next cycle. If it coincides with a lower-half bus write to the same entry, the side-port value is kept. Indices of 24 or more are ignored.
- R12: `engEntry` shows entry `engIdx` combinationally, and shows 0 for an index of 24 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busOffset | input | 8 | Byte offset inside the 256-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| pendingBits | input | 24 | Per-pin pending flags from the engine |
| remoteSetValid | input | 1 | Side-port remote-IRR update strobe |
| remoteSetIdx | input | 5 | Entry updated by the side port |
| remoteSetVal | input | 1 | New remote-IRR value |
| engIdx | input | 5 | Entry lookup index for the engine |
| engEntry | output | 64 | Entry contents at `engIdx` |
| svcReq | output | 1 | One-cycle service request |
| svcPin | output | 5 | Pin named by the service request |

## Verification
Read data and service requests come from registers clocked by the request edge, so both are due exactly one cycle after the stimulus. Table, identifier and selector updates become visible on the lookup port in that same next cycle. Before each clock edge, the bench's behavioural model works out what the outputs will be after that edge from the inputs in force. It then compares `busRdata`, `svcReq`/`svcPin` and `engEntry` one time unit after the edge, when no output is still settling. Because this comparison runs on every clock, a one-cycle-early or one-cycle-late result is caught as well as a wrong value.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int REMOTE_BIT = 14;
  localparam int MASK_BIT   = 16;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_LO,
    RD_HI
  } rdSrc_e;

  typedef struct packed {
    logic   idWr;
    logic   loWr;
    logic   hiWr;
    logic   rdEn;
    rdSrc_e rdSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5,
  parameter int OFF_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [OFF_W-1:0] busOffset,
  input  logic [31:0]      busWdata,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] entryIdx,
  output logic [31:0]      selReg
);

  localparam logic [OFF_W-1:0] SEL_OFF   = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] WIN_OFF   = OFF_W'(8'h10);
  localparam logic [31:0]      TBL_FIRST = 32'h10;

  logic        hitSel;
  logic        hitWin;
  logic        winWrite;
  logic [31:0] entryNum;
  logic        entryOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
    end else if (busValid && busWrite && hitSel) begin
      selReg <= busWdata;
    end
  end

  always_comb begin
    hitSel   = (busOffset == SEL_OFF);
    hitWin   = (busOffset == WIN_OFF);
    winWrite = busValid && busWrite && hitWin;
    entryNum = (selReg - TBL_FIRST) >> 1;
    entryOk  = (selReg >= TBL_FIRST) && (entryNum < 32'(NUM_PINS));
    entryIdx = entryNum[IDX_W-1:0];

    strobe.idWr = winWrite && (selReg == 32'd0);
    strobe.loWr = winWrite && entryOk && !selReg[0];
    strobe.hiWr = winWrite && entryOk && selReg[0];
    strobe.rdEn = busValid && !busWrite;

    if (hitSel) begin
      strobe.rdSrc = RD_SEL;
    end else if (hitWin) begin
      case (selReg)
        32'd0:   strobe.rdSrc = RD_ID;
        32'd1:   strobe.rdSrc = RD_VER;
        32'd2:   strobe.rdSrc = RD_ID;
        default: strobe.rdSrc = entryOk ? (selReg[0] ? RD_HI : RD_LO) : RD_ZERO;
      endcase
    end else begin
      strobe.rdSrc = RD_ZERO;
    end
  end

endmodule

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
#(
  parameter int          NUM_PINS     = 24,
  parameter int          IDX_W        = 5,
  parameter logic [7:0]  VERSION_CODE = 8'h11
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [IDX_W-1:0]    entryIdx,
  input  logic [31:0]         selReg,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PINS-1:0] pendingBits,
  input  logic                remoteSetValid,
  input  logic [IDX_W-1:0]    remoteSetIdx,
  input  logic                remoteSetVal,
  input  logic [IDX_W-1:0]    engIdx,
  output logic [31:0]         busRdata,
  output logic [63:0]         engEntry,
  output logic                svcReq,
  output logic [IDX_W-1:0]    svcPin
);

  localparam logic [63:0] RESET_ENTRY = 64'(1) << MASK_BIT;
  localparam logic [7:0]  MAX_ENTRY   = 8'(NUM_PINS - 1);
  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W + 1)'(NUM_PINS);

  logic [63:0] tbl [NUM_PINS];
  logic [3:0]  idReg;
  logic [31:0] rdVal;

  // Table update: bus write first, side port last so it wins on a collision.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        tbl[i] <= RESET_ENTRY;
      end
    end else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (strobe.loWr && (entryIdx == IDX_W'(i))) begin
          tbl[i][31:0]       <= busWdata;
          tbl[i][REMOTE_BIT] <= 1'b0;
        end
        if (strobe.hiWr && (entryIdx == IDX_W'(i))) begin
          tbl[i][63:32] <= busWdata;
        end
        if (remoteSetValid && (remoteSetIdx == IDX_W'(i))) begin
          tbl[i][REMOTE_BIT] <= remoteSetVal;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= '0;
    end else if (strobe.idWr) begin
      idReg <= busWdata[27:24];
    end
  end

  always_comb begin
    case (strobe.rdSrc)
      RD_SEL:  rdVal = selReg;
      RD_ID:   rdVal = {4'd0, idReg, 24'd0};
      RD_VER:  rdVal = {8'd0, MAX_ENTRY, 8'd0, VERSION_CODE};
      RD_LO:   rdVal = tbl[entryIdx][31:0];
      RD_HI:   rdVal = tbl[entryIdx][63:32];
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      svcReq   <= 1'b0;
      svcPin   <= '0;
    end else begin
      busRdata <= strobe.rdEn ? rdVal : '0;
      svcReq   <= (strobe.loWr || strobe.hiWr) && pendingBits[entryIdx];
      if (strobe.loWr || strobe.hiWr) begin
        svcPin <= entryIdx;
      end
    end
  end

  assign engEntry = ({1'b0, engIdx} < PIN_LIMIT) ? tbl[engIdx] : 64'd0;

endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS     = 24,
  parameter int         OFF_W        = 8,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int        IDX_W        = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [OFF_W-1:0]    busOffset,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] pendingBits,
  input  logic                remoteSetValid,
  input  logic [IDX_W-1:0]    remoteSetIdx,
  input  logic                remoteSetVal,
  input  logic [IDX_W-1:0]    engIdx,
  output logic [63:0]         engEntry,
  output logic                svcReq,
  output logic [IDX_W-1:0]    svcPin
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] entryIdx;
  logic [31:0]      selReg;

  irq_redir_ctrl #(
    .NUM_PINS(NUM_PINS),
    .IDX_W   (IDX_W),
    .OFF_W   (OFF_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busOffset(busOffset),
    .busWdata (busWdata),
    .strobe   (strobe),
    .entryIdx (entryIdx),
    .selReg   (selReg)
  );

  irq_redir_dp #(
    .NUM_PINS    (NUM_PINS),
    .IDX_W       (IDX_W),
    .VERSION_CODE(VERSION_CODE)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .entryIdx      (entryIdx),
    .selReg        (selReg),
    .busWdata      (busWdata),
    .pendingBits   (pendingBits),
    .remoteSetValid(remoteSetValid),
    .remoteSetIdx  (remoteSetIdx),
    .remoteSetVal  (remoteSetVal),
    .engIdx        (engIdx),
    .busRdata      (busRdata),
    .engEntry      (engEntry),
    .svcReq        (svcReq),
    .svcPin        (svcPin)
  );

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int NUM_PINS = 24,
  parameter int OFF_W    = 8,
  parameter int IDX_W    = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic [OFF_W-1:0] busOffset,
  input logic [31:0]      busRdata,
  input logic             remoteSetValid,
  input logic [IDX_W-1:0] remoteSetIdx,
  input logic             remoteSetVal,
  input logic [IDX_W-1:0] engIdx,
  input logic [63:0]      engEntry,
  input logic             svcReq,
  input logic [IDX_W-1:0] svcPin
);

  localparam logic [OFF_W-1:0] SEL_OFF   = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] WIN_OFF   = OFF_W'(8'h10);
  localparam logic [IDX_W:0]   PIN_LIMIT = (IDX_W + 1)'(NUM_PINS);

  // R1: no read request in the previous cycle means zero read data
  p_rd_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid && !busWrite) |-> busRdata == 32'd0);

  // R2: reads outside the two live offsets return zero
  p_rd_hole_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(busValid && !busWrite && busOffset != SEL_OFF && busOffset != WIN_OFF)
    |-> busRdata == 32'd0);

  // R10: a service request only follows a write to the data port
  p_svc_after_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> $past(busValid && busWrite && busOffset == WIN_OFF));

  // R10: the requested pin exists
  p_svc_pin_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> {1'b0, svcPin} < PIN_LIMIT);

  // R11: side-port remote IRR value is visible on the lookup port next cycle
  p_remote_side_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(remoteSetValid) && $past(remoteSetIdx) == engIdx && {1'b0, engIdx} < PIN_LIMIT)
    |-> engEntry[14] == $past(remoteSetVal));

  // R12: lookup beyond the table shows zero
  p_eng_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, engIdx} >= PIN_LIMIT |-> engEntry == 64'd0);

endmodule

bind irq_redir_regs irq_redir_chk #(
  .NUM_PINS(NUM_PINS),
  .OFF_W   (OFF_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busValid      (busValid),
  .busWrite      (busWrite),
  .busOffset     (busOffset),
  .busRdata      (busRdata),
  .remoteSetValid(remoteSetValid),
  .remoteSetIdx  (remoteSetIdx),
  .remoteSetVal  (remoteSetVal),
  .engIdx        (engIdx),
  .engEntry      (engEntry),
  .svcReq        (svcReq),
  .svcPin        (svcPin)
);

// File: tb/irq_redir_regs_tb.sv
module irq_redir_regs_tb;

  localparam int CLK_P = 10;
  localparam int NP    = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busOffset = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [23:0] pendingBits = '0;
  logic        remoteSetValid = 1'b0;
  logic [4:0]  remoteSetIdx = '0;
  logic        remoteSetVal = 1'b0;
  logic [4:0]  engIdx = '0;
  logic [63:0] engEntry;
  logic        svcReq;
  logic [4:0]  svcPin;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mTbl [NP];
  logic [3:0]  mId;
  logic [31:0] mSel;

  always #(CLK_P / 2) clk = ~clk;

  irq_redir_regs u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busOffset(busOffset), .busWdata(busWdata), .busRdata(busRdata),
    .pendingBits(pendingBits), .remoteSetValid(remoteSetValid),
    .remoteSetIdx(remoteSetIdx), .remoteSetVal(remoteSetVal),
    .engIdx(engIdx), .engEntry(engEntry), .svcReq(svcReq), .svcPin(svcPin)
  );

  function automatic logic [31:0] modelRead(logic [7:0] off);
    longint n;
    if (off == 8'h00) return mSel;
    if (off != 8'h10) return 32'd0;
    if (mSel == 0 || mSel == 2) return {4'd0, mId, 24'd0};
    if (mSel == 1) return 32'h0017_0011;
    if (mSel < 32'h10) return 32'd0;
    n = (longint'(mSel) - 16) / 2;
    if (n >= NP) return 32'd0;
    return mSel[0] ? mTbl[n][63:32] : mTbl[n][31:0];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NP; i++) mTbl[i] = 64'h0000_0000_0001_0000;
    mId  = '0;
    mSel = '0;
  endtask

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock: predict, let the edge pass, compare one time unit later.
  task automatic tick(string tag);
    logic [31:0] expRd;
    logic        expSvc;
    logic [4:0]  expPin;
    longint      n;
    expRd  = (busValid && !busWrite) ? modelRead(busOffset) : 32'd0;
    expSvc = 1'b0;
    expPin = '0;
    if (busValid && busWrite) begin
      if (busOffset == 8'h00) mSel = busWdata;
      else if (busOffset == 8'h10) begin
        if (mSel == 0) mId = busWdata[27:24];
        else if (mSel >= 32'h10) begin
          n = (longint'(mSel) - 16) / 2;
          if (n < NP) begin
            if (mSel[0]) mTbl[n][63:32] = busWdata;
            else begin
              mTbl[n][31:0] = busWdata;
              mTbl[n][14]   = 1'b0;
            end
            expSvc = pendingBits[n];
            expPin = 5'(n);
          end
        end
      end
    end
    if (remoteSetValid && remoteSetIdx < NP) mTbl[remoteSetIdx][14] = remoteSetVal;
    @(posedge clk);
    #1;
    check(tag, "busRdata", 64'(busRdata), 64'(expRd));
    check("R10", "svcReq", 64'(svcReq), 64'(expSvc));
    if (expSvc) check("R10", "svcPin", 64'(svcPin), 64'(expPin));
    check(engIdx < NP ? tag : "R12", "engEntry", engEntry,
          engIdx < NP ? mTbl[engIdx] : 64'd0);
  endtask

  task automatic busWr(logic [7:0] off, logic [31:0] d, string tag);
    busValid = 1'b1; busWrite = 1'b1; busOffset = off; busWdata = d;
    tick(tag);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [7:0] off, string tag);
    busValid = 1'b1; busWrite = 1'b0; busOffset = off;
    tick(tag);
    busValid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;

    // R9: reset contents of every entry, then selector and identifier
    for (int i = 0; i < NP; i++) begin
      engIdx = 5'(i);
      tick("R9");
    end
    busRd(8'h00, "R9");
    busRd(8'h10, "R9");

    // R1: selector write and readback, idle cycles
    busWr(8'h00, 32'h1234_5678, "R1");
    busRd(8'h00, "R1");
    tick("R1");

    // R2: holes in the window
    busWr(8'h20, 32'hFFFF_FFFF, "R2");
    busWr(8'hF0, 32'h0000_0000, "R2");
    busRd(8'h20, "R2");
    busRd(8'h04, "R2");
    busRd(8'h00, "R2");

    // R3: identifier
    busWr(8'h00, 32'd0, "R3");
    busWr(8'h10, 32'hFFFF_FFFF, "R3");
    busRd(8'h10, "R3");
    busWr(8'h10, 32'h0A00_0000, "R3");
    busRd(8'h10, "R3");

    // R4: version is read-only
    busWr(8'h00, 32'd1, "R4");
    busRd(8'h10, "R4");
    busWr(8'h10, 32'hFFFF_FFFF, "R4");
    busRd(8'h10, "R4");

    // R5: arbitration word mirrors identifier, ignores writes
    busWr(8'h00, 32'd2, "R5");
    busWr(8'h10, 32'h0500_0000, "R5");
    busRd(8'h10, "R5");
    busWr(8'h00, 32'd0, "R5");
    busRd(8'h10, "R5");

    // R6/R7: entry 5 halves, remote IRR handling
    engIdx = 5'd5;
    busWr(8'h00, 32'h1A, "R6");
    busWr(8'h10, 32'h0001_C0B1, "R7");
    busRd(8'h10, "R7");
    busWr(8'h00, 32'h1B, "R6");
    busWr(8'h10, 32'hAB00_0000, "R6");
    busRd(8'h10, "R6");
    remoteSetValid = 1'b1; remoteSetIdx = 5'd5; remoteSetVal = 1'b1;
    tick("R11");
    remoteSetValid = 1'b0;
    busWr(8'h10, 32'hCD00_0000, "R7");
    busWr(8'h00, 32'h1A, "R7");
    busRd(8'h10, "R7");
    busWr(8'h10, 32'h0000_8031, "R7");
    busRd(8'h10, "R7");

    // R11: collision, side port wins; then clear; out-of-range ignored
    remoteSetValid = 1'b1; remoteSetIdx = 5'd5; remoteSetVal = 1'b1;
    busWr(8'h10, 32'h0000_4031, "R11");
    remoteSetVal = 1'b0;
    tick("R11");
    remoteSetIdx = 5'd30; remoteSetVal = 1'b1;
    tick("R11");
    remoteSetValid = 1'b0;

    // R10: service requests for pending pins, including the last pin
    pendingBits = 24'h80_0080;
    engIdx = 5'd7;
    busWr(8'h00, 32'h1E, "R10");
    busWr(8'h10, 32'h0000_A041, "R10");
    tick("R10");
    busWr(8'h00, 32'h3F, "R10");
    busWr(8'h10, 32'hFF00_0000, "R10");
    busWr(8'h10, 32'h1100_0000, "R10");
    busWr(8'h00, 32'h1A, "R10");
    busWr(8'h10, 32'h0000_0031, "R10");
    pendingBits = '0;
    busWr(8'h00, 32'h3E, "R10");
    busWr(8'h10, 32'h0001_0022, "R10");
    engIdx = 5'd23;
    busRd(8'h10, "R6");

    // R8: out-of-range and reserved selectors
    pendingBits = 24'hFF_FFFF;
    busWr(8'h00, 32'h40, "R8");
    busWr(8'h10, 32'hDEAD_BEEF, "R8");
    busRd(8'h10, "R8");
    busWr(8'h00, 32'h8000_0011, "R8");
    busWr(8'h10, 32'hDEAD_BEEF, "R8");
    busRd(8'h10, "R8");
    busWr(8'h00, 32'h05, "R8");
    busWr(8'h10, 32'hDEAD_BEEF, "R8");
    busRd(8'h10, "R8");
    pendingBits = '0;
    busWr(8'h00, 32'd0, "R8");
    busRd(8'h10, "R8");

    // R12: lookup port past the table
    for (int i = NP; i < 32; i++) begin
      engIdx = 5'(i);
      tick("R12");
    end
    for (int i = 0; i < NP; i++) begin
      engIdx = 5'(i);
      tick("R12");
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule